// File: doc/BRIEF.md
# PDM Microphone Clock and Capture Front-End

This block drives the clock line for one or two external pulse-density-modulated microphones and collects their one-bit output streams. It runs entirely on a 24 MHz reference clock. The microphone clock is made by dividing that reference by an even ratio chosen at run time, so the high and low halves always match. Power-down parks the clock low.

The block supports two wirings. In one-mic-per-pin (uniplex) mode, each data pin has its own microphone, and both pins are sampled on the rising microphone-clock edge. In shared-pin (multiplex) mode, two microphones share the first data pin. The left microphone is taken on the rising edge and the right microphone on the falling edge.

Each capture appears as a one-cycle valid strobe with its bit. Decimation to PCM is done downstream. Rate and wiring changes are taken only when a low phase completes, so no short pulse reaches the microphones. Captures resume only after one whole period at the new setting has run.

Top module: `pdm_mic_capture`

## Requirements
- R1: `rate_sel` picks the reference division ratio. Code 0 divides by DIV_SLOW (16, 1.5 MHz), code 1 by DIV_MID (12, 2.0 MHz), and codes 2 and 3 by DIV_FAST (8, 3.0 MHz). Each high phase of `mic_clk` lasts half that ratio in reference cycles.
- R2: Every low phase of `mic_clk` lasts exactly as long as the high phase that precedes it (50/50 duty).
- R3: A change of `rate_sel` or `mux_mode` is taken only at the end of a low phase. No high pulse ever has a width other than 4, 6 or 8 reference cycles.
- R4: With `mux_mode`=0 (uniplex), on each rising `mic_clk` edge `pdm_a` is captured to `left_bit` and `pdm_b` to `right_bit`. `left_valid` and `right_valid` pulse together.
- R5: With `mux_mode`=1 (multiplex), `pdm_a` is captured to `left_bit` on the rising edge and to `right_bit` on the falling edge. `pdm_b` has no effect on any output.
- R6: Each valid strobe is high for one reference cycle, right after the reference edge that makes the matching `mic_clk` transition. Each channel gives exactly one capture per microphone-clock period.
- R7: After a setting change or a power-down release, the first `mic_clk` rise is not captured, and nothing is captured during that first period. `left_valid` first rises exactly one period (the division ratio) after that rise.
- R8: While `pwr_down` is high, `mic_clk` is held low from the next reference edge and both valid strobes stay low.
- R9: In reset, `mic_clk`, `left_valid` and `right_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_down | input | 1 | Stop the microphone clock and captures |
| rate_sel | input | 2 | Division ratio select (see R1) |
| mux_mode | input | 1 | 0 = one mic per pin, 1 = two mics on `pdm_a` |
| pdm_a | input | 1 | First microphone data pin |
| pdm_b | input | 1 | Second microphone data pin (uniplex only) |
| mic_clk | output | 1 | Clock to the microphones |
| left_bit | output | 1 | Captured left-channel bit |
| left_valid | output | 1 | One-cycle strobe for `left_bit` |
| right_bit | output | 1 | Captured right-channel bit |
| right_valid | output | 1 | One-cycle strobe for `right_bit` |

## Verification
The bench builds the block with its default ratios of 16, 12 and 8. Because these are small, every rate code, including the alias code 3, is swept in both wiring modes. Each sweep point covers a warm-up check and a fixed window of thirty periods. Microphone models drive data on the edge opposite the capture edge, from pseudo-random sequences, and each captured bit is compared with the bit the model is holding. The second pin is driven with junk while multiplex mode is active. Every clock pulse width is measured across each transition, and also across a power-down interval.

// File: rtl/pdm_mic_capture.sv
module pdm_mic_capture #(
  parameter int DIV_SLOW = 16,
  parameter int DIV_MID  = 12,
  parameter int DIV_FAST = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_down,
  input  logic [1:0] rate_sel,
  input  logic       mux_mode,
  input  logic       pdm_a,
  input  logic       pdm_b,
  output logic       mic_clk,
  output logic       left_bit,
  output logic       left_valid,
  output logic       right_bit,
  output logic       right_valid
);
  localparam int MAXD = (DIV_SLOW > DIV_MID) ? ((DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST)
                                             : ((DIV_MID > DIV_FAST) ? DIV_MID : DIV_FAST);
  localparam int CW = $clog2(MAXD);

  function automatic logic [CW-1:0] last_of(input logic [1:0] r);
    case (r)
      2'd0:    last_of = CW'(DIV_SLOW - 1);
      2'd1:    last_of = CW'(DIV_MID - 1);
      default: last_of = CW'(DIV_FAST - 1);
    endcase
  endfunction

  logic [CW-1:0] cnt;
  logic [1:0]    rate_q;
  logic          mux_q, fresh, settled;

  wire [CW-1:0] last_c   = last_of(rate_q);
  wire          at_end   = (cnt == last_c);
  wire          at_mid   = (cnt == (last_c >> 1));
  wire          restart  = fresh | ({rate_sel, mux_mode} != {rate_q, mux_q});
  wire          rise_cap = at_end & ~restart;
  wire          fall_cap = at_mid & settled & mux_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= CW'(DIV_SLOW - 1);
      rate_q      <= 2'd0;
      mux_q       <= 1'b0;
      fresh       <= 1'b1;
      settled     <= 1'b0;
      mic_clk     <= 1'b0;
      left_valid  <= 1'b0;
      right_valid <= 1'b0;
      left_bit    <= 1'b0;
      right_bit   <= 1'b0;
    end else if (pwr_down) begin
      cnt         <= last_of(rate_sel);
      rate_q      <= rate_sel;
      mux_q       <= mux_mode;
      fresh       <= 1'b1;
      settled     <= 1'b0;
      mic_clk     <= 1'b0;
      left_valid  <= 1'b0;
      right_valid <= 1'b0;
    end else begin
      left_valid  <= rise_cap;
      right_valid <= mux_q ? fall_cap : rise_cap;
      if (rise_cap) begin
        left_bit <= pdm_a;
        if (!mux_q) right_bit <= pdm_b;
      end
      if (fall_cap) right_bit <= pdm_a;
      if (at_end) begin
        cnt     <= '0;
        mic_clk <= 1'b1;
        rate_q  <= rate_sel;
        mux_q   <= mux_mode;
        fresh   <= 1'b0;
        settled <= ~restart;
      end else begin
        cnt <= cnt + 1'b1;
        if (at_mid) mic_clk <= 1'b0;
      end
    end
  end

  a_r4_uni_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (!mux_q && left_valid) |-> right_valid);

  a_r5_mux_right_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_q && right_valid) |-> $fell(mic_clk));

  a_r6_left_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    left_valid |-> $rose(mic_clk));

  a_r8_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (!mic_clk && !left_valid && !right_valid));

  a_r3_high_only_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mic_clk) |-> (cnt == '0));
endmodule

// File: tb/pdm_mic_capture_bench.sv
module pdm_mic_capture_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_down = 1'b1;
  logic [1:0] rate_sel = 2'd0;
  logic mux_mode = 1'b0;
  logic pdm_a = 1'b0;
  logic pdm_b = 1'b0;
  logic mic_clk, left_bit, left_valid, right_bit, right_valid;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pdm_mic_capture u_pdm_mic_capture (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .rate_sel(rate_sel),
    .mux_mode(mux_mode), .pdm_a(pdm_a), .pdm_b(pdm_b), .mic_clk(mic_clk),
    .left_bit(left_bit), .left_valid(left_valid),
    .right_bit(right_bit), .right_valid(right_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] r);
    return (r == 2'd0) ? 16 : (r == 2'd1) ? 12 : 8;
  endfunction

  function automatic logic [15:0] step(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  // microphone models: drive on the edge opposite to capture
  logic mode_b = 1'b0;
  logic [15:0] lf_l = 16'hACE1, lf_r = 16'h1D2B, lf_j = 16'h7F31;
  logic l_cur = 1'b0, r_cur = 1'b0;

  always @(negedge mic_clk) begin
    #2;
    lf_l = step(lf_l);
    l_cur = lf_l[0];
    pdm_a = l_cur;
    if (!mode_b) begin
      lf_r = step(lf_r);
      r_cur = lf_r[0];
      pdm_b = r_cur;
    end else begin
      lf_j = step(lf_j);
      pdm_b = lf_j[3];
    end
  end

  always @(posedge mic_clk) begin
    #2;
    if (mode_b) begin
      lf_r = step(lf_r);
      r_cur = lf_r[0];
      pdm_a = r_cur;
      lf_j = step(lf_j);
      pdm_b = lf_j[5];
    end
  end

  // data checks
  logic chk_en = 1'b0;
  always @(negedge clk) begin
    if (chk_en) begin
      if (left_valid)
        chk(left_bit == l_cur, mode_b ? "R5 left" : "R4 left", int'(left_bit), int'(l_cur));
      if (right_valid)
        chk(right_bit == r_cur, mode_b ? "R5 right" : "R4 right", int'(right_bit), int'(r_cur));
    end
  end

  // pulse-width monitor
  int exp_half = 0;
  int hi = 0, lo = 0, last_hi = 0;
  logic prev_mc = 1'b0, have_rise = 1'b0, have_fall = 1'b0;
  always @(negedge clk) begin
    if (!rst_n || pwr_down) begin
      have_rise = 1'b0; have_fall = 1'b0; hi = 0; lo = 0;
    end else begin
      if (mic_clk && !prev_mc) begin
        if (have_fall) chk(lo == last_hi, "R2 low equals high", lo, last_hi);
        have_rise = 1'b1; hi = 1;
      end else if (!mic_clk && prev_mc) begin
        if (have_rise) begin
          if (chk_en) chk(hi == exp_half, "R1 high width", hi, exp_half);
          else chk(hi == 4 || hi == 6 || hi == 8, "R3 no runt", hi, 0);
          last_hi = hi; have_fall = 1'b1;
        end
        lo = 1;
      end else if (mic_clk) hi++;
      else lo++;
    end
    prev_mc = mic_clk;
  end

  task automatic run_cfg(input logic [1:0] r, input logic m);
    int n, nl, nr, d;
    d = div_of(r);
    @(posedge clk); #2;
    chk_en = 1'b0;
    rate_sel = r; mux_mode = m; mode_b = m; pwr_down = 1'b0;
    @(posedge mic_clk);
    n = 0;
    do begin
      @(negedge clk); n++;
      if (right_valid && n <= d) chk(1'b0, "R7 right during warm-up", n, 0);
    end while (!left_valid && n < 3 * d);
    chk(n == d + 1, "R7 first left valid delay", n, d + 1);
    exp_half = d / 2;
    chk_en = 1'b1;
    nl = 0; nr = 0;
    repeat (30 * d) begin
      @(negedge clk);
      if (left_valid) nl++;
      if (right_valid) nr++;
    end
    chk(nl == 30, "R6 left captures per window", nl, 30);
    chk(nr == 30, "R6 right captures per window", nr, 30);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!mic_clk && !left_valid && !right_valid, "R9 reset state",
        int'({mic_clk, left_valid, right_valid}), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (20) begin
      @(negedge clk);
      chk(!mic_clk && !left_valid && !right_valid, "R8 held in power-down",
          int'({mic_clk, left_valid, right_valid}), 0);
    end
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 4; r++)
        run_cfg(2'(r), 1'(m));
    @(posedge clk); #2;
    chk_en = 1'b0;
    pwr_down = 1'b1;
    @(negedge clk);
    repeat (50) begin
      @(negedge clk);
      chk(!mic_clk && !left_valid && !right_valid, "R8 quiet after power-down",
          int'({mic_clk, left_valid, right_valid}), 0);
    end
    run_cfg(2'd1, 1'b1);
    run_cfg(2'd0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule